// File: doc/BRIEF.md
# Cyclic Transmit Gate Scheduler

The block opens and closes the transmit gates of a small group of egress queues on a repeating time plan. A free-running nanosecond counter is an input. Software first programs a plan: a cycle length, a start offset and an end offset for each queue, a strict-fit mask, and a first-cycle base time held as whole seconds plus nanoseconds. Software then raises the enable. If the base time is already in the past, the block moves it forward to the next cycle boundary. After that the cycle start advances by itself every cycle, with no further software action.

Each queue has a gate output that is high while the time elapsed in the current cycle lies inside that queue's window. Each queue also has an admit output. Admit tells the transmit engine whether the frame now pending on that queue may start. It depends on the gate, on a frame-size cap that changes with the mode, and, for strict queues, on whether the frame can finish before the window closes in this cycle. The frame duration is the byte count times eight times the nanoseconds per bit of the link.

Offsets and cycle values written while the plan is running are held in a shadow copy and are applied together at the next cycle boundary. Only a reset returns the block to the idle, always-open state.

Top module: `tx_gate_sched`

## Requirements
- R1: After reset the block is idle and every gate output is high, whatever the time input shows.
- R2: While idle, a queue is admitted when its pending length is 9728 bytes or less and refused above that. Strict settings have no effect while idle.
- R3: When the programmed base time is later than the current time, the first cycle starts exactly at that base time. Between enable and that instant all gates are low.
- R4: When the base time is not later than the current time, the first cycle starts at base + (n+1)·cycle, where n = floor((now − base)/cycle). Gates stay low until then.
- R5: While running, gate q is high exactly when start_q <= (now − cycle_start) < end_q.
- R6: A queue whose end offset is not greater than its start offset never opens while running.
- R7: When now reaches cycle_start + cycle, the cycle start moves forward by one cycle, and the windows repeat in the same cycle in which the boundary is reached.
- R8: For a queue with its strict bit set, admit is high only if the gate is open, the length is within the cap, and now + length·8·ns_per_bit <= cycle_start + end_q.
- R9: For a queue with its strict bit clear, admit equals gate AND (length <= cap). Admit is never high while the gate is low.
- R10: While running, the cap is 1600 bytes, so a longer frame is never admitted.
- R11: Writes to the cycle, strict mask or offsets while running take effect at the first boundary after the write has been registered. A write made in the very cycle of a boundary waits for the following boundary.
- R12: Once running, the block ignores a falling enable and any write to the base-time registers. Only reset returns it to idle.
- R13: Register addresses are: 0 = base nanoseconds within the second (bits 29:0), 1 = base seconds, 2 = cycle time in ns, 3 = strict mask (bit q for queue q), 4+2q = start offset of queue q, 5+2q = end offset of queue q. The reset values are 0, 0, 1e9, 0, 0 and 1e9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the block to idle |
| now_ns | input | TW | Free-running time in nanoseconds |
| sched_en | input | 1 | Starts the programmed plan when the block is idle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDRW | Register address |
| cfg_wdata | input | DW | Register write data |
| frame_len | input | NQ*LENW | Pending frame length in bytes, one LENW field per queue, queue 0 in the low bits |
| ns_per_bit | input | NPBW | Link speed as nanoseconds per bit |
| gate_open | output | NQ | Gate state per queue |
| admit | output | NQ | Frame may start, per queue |

## Verification
Two events can coincide: a cycle boundary, where the shadow plan is loaded, and a register write to that same shadow. The bench's reference model predicts the cycle in which the next rollover falls and issues an offset write in exactly that cycle. It then expects the old plan to be loaded at this boundary and the new offset to appear only one full cycle later. Strict admission is the second contested point. Near the window end of a strict queue, the gate and the fit test disagree, and the model compares admit against the gate on every clock.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } tgs_state_e;

    localparam int unsigned NS_PER_SEC      = 1000000000;
    localparam int unsigned SCHED_MAX_BYTES = 1600;
    localparam int unsigned JUMBO_MAX_BYTES = 9728;
endpackage

// File: rtl/tgs_cfg_regs.sv
// Shadow copy of the programmed plan; the running copy lives in the top.
module tgs_cfg_regs
    import tgs_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int TW    = 48,
    parameter int OFFW  = 32,
    parameter int SECW  = 16,
    parameter int DW    = 32,
    parameter int ADDRW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDRW-1:0]         addr,
    input  logic [DW-1:0]            wdata,
    output logic [TW-1:0]            base_abs,
    output logic [OFFW-1:0]          sh_cyc,
    output logic [NQ-1:0]            sh_strict,
    output logic [NQ-1:0][OFFW-1:0]  sh_st,
    output logic [NQ-1:0][OFFW-1:0]  sh_en
);
    typedef struct packed {
        logic [29:0]             nsec;
        logic [SECW-1:0]         sec;
        logic [OFFW-1:0]         cyc;
        logic [NQ-1:0]           strict;
        logic [NQ-1:0][OFFW-1:0] st;
        logic [NQ-1:0][OFFW-1:0] en;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            unique case (int'(addr))
                0: s_d.nsec   = wdata[29:0];
                1: s_d.sec    = wdata[SECW-1:0];
                2: s_d.cyc    = wdata[OFFW-1:0];
                3: s_d.strict = wdata[NQ-1:0];
                default: begin
                    for (int q = 0; q < NQ; q++) begin
                        if (int'(addr) == 4 + 2 * q) s_d.st[q] = wdata[OFFW-1:0];
                        if (int'(addr) == 5 + 2 * q) s_d.en[q] = wdata[OFFW-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.nsec   <= '0;
            s_q.sec    <= '0;
            s_q.cyc    <= OFFW'(NS_PER_SEC);
            s_q.strict <= '0;
            for (int q = 0; q < NQ; q++) begin
                s_q.st[q] <= '0;
                s_q.en[q] <= OFFW'(NS_PER_SEC);
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign base_abs  = TW'(s_q.sec) * TW'(NS_PER_SEC) + TW'(s_q.nsec);
    assign sh_cyc    = s_q.cyc;
    assign sh_strict = s_q.strict;
    assign sh_st     = s_q.st;
    assign sh_en     = s_q.en;
endmodule

// File: rtl/tgs_queue_gate.sv
// Window test and frame-fit admission for one queue.
module tgs_queue_gate
    import tgs_pkg::*;
#(
    parameter int TW   = 48,
    parameter int OFFW = 32,
    parameter int LENW = 14,
    parameter int NPBW = 4
) (
    input  logic            idle,
    input  logic            live,
    input  logic [TW-1:0]   now,
    input  logic [TW-1:0]   cs,
    input  logic [OFFW-1:0] start_off,
    input  logic [OFFW-1:0] end_off,
    input  logic            strict,
    input  logic [LENW-1:0] len,
    input  logic [NPBW-1:0] npb,
    output logic            gate,
    output logic            admit
);
    localparam int DURW = LENW + 3 + NPBW;

    logic [TW-1:0]   elapsed;
    logic [TW-1:0]   win_end;
    logic [TW-1:0]   finish;
    logic [DURW-1:0] dur;
    logic            in_win;
    logic            len_ok;
    logic            fits;

    assign elapsed = now - cs;
    assign win_end = cs + TW'(end_off);
    assign dur     = DURW'({len, 3'b000}) * DURW'(npb);
    assign finish  = now + TW'(dur);
    assign in_win  = live && (elapsed >= TW'(start_off)) && (elapsed < TW'(end_off));
    assign fits    = finish <= win_end;
    assign len_ok  = idle ? (32'(len) <= JUMBO_MAX_BYTES) : (32'(len) <= SCHED_MAX_BYTES);

    assign gate  = idle | in_win;
    assign admit = gate & len_ok & (idle | ~strict | fits);
endmodule

// File: rtl/tx_gate_sched.sv
module tx_gate_sched
    import tgs_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int TW   = 48,
    parameter int OFFW = 32,
    parameter int SECW = 16,
    parameter int LENW = 14,
    parameter int NPBW = 4,
    parameter int DW   = 32,
    localparam int ADDRW = $clog2(4 + 2 * NQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        now_ns,
    input  logic                 sched_en,
    input  logic                 cfg_we,
    input  logic [ADDRW-1:0]     cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic [NQ*LENW-1:0]   frame_len,
    input  logic [NPBW-1:0]      ns_per_bit,
    output logic [NQ-1:0]        gate_open,
    output logic [NQ-1:0]        admit
);
    typedef struct packed {
        tgs_state_e              state;
        logic [TW-1:0]           cs;
        logic [OFFW-1:0]         cyc;
        logic [NQ-1:0]           strict;
        logic [NQ-1:0][OFFW-1:0] st;
        logic [NQ-1:0][OFFW-1:0] en;
    } run_t;

    run_t r_d, r_q;

    logic [TW-1:0]           base_abs;
    logic [OFFW-1:0]         sh_cyc;
    logic [NQ-1:0]           sh_strict;
    logic [NQ-1:0][OFFW-1:0] sh_st;
    logic [NQ-1:0][OFFW-1:0] sh_en;
    logic                    is_idle;
    logic                    is_live;

    tgs_cfg_regs #(
        .NQ(NQ), .TW(TW), .OFFW(OFFW), .SECW(SECW), .DW(DW), .ADDRW(ADDRW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .base_abs  (base_abs),
        .sh_cyc    (sh_cyc),
        .sh_strict (sh_strict),
        .sh_st     (sh_st),
        .sh_en     (sh_en)
    );

    // r_d doubles as the plan in force during this clock when running.
    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (sched_en) begin
                    r_d.state  = ST_ALIGN;
                    r_d.cs     = base_abs;
                    r_d.cyc    = sh_cyc;
                    r_d.strict = sh_strict;
                    r_d.st     = sh_st;
                    r_d.en     = sh_en;
                end
            end
            ST_ALIGN: begin
                if (r_q.cs > now_ns) r_d.state = ST_RUN;
                else                 r_d.cs    = r_q.cs + TW'(r_q.cyc);
            end
            ST_RUN: begin
                if (now_ns >= r_q.cs + TW'(r_q.cyc)) begin
                    r_d.cs     = r_q.cs + TW'(r_q.cyc);
                    r_d.cyc    = sh_cyc;
                    r_d.strict = sh_strict;
                    r_d.st     = sh_st;
                    r_d.en     = sh_en;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.cs     <= '0;
            r_q.cyc    <= OFFW'(NS_PER_SEC);
            r_q.strict <= '0;
            for (int q = 0; q < NQ; q++) begin
                r_q.st[q] <= '0;
                r_q.en[q] <= OFFW'(NS_PER_SEC);
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign is_idle = (r_q.state == ST_IDLE);
    assign is_live = (r_q.state == ST_RUN) && (now_ns >= r_d.cs);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        tgs_queue_gate #(
            .TW(TW), .OFFW(OFFW), .LENW(LENW), .NPBW(NPBW)
        ) u_q (
            .idle      (is_idle),
            .live      (is_live),
            .now       (now_ns),
            .cs        (r_d.cs),
            .start_off (r_d.st[q]),
            .end_off   (r_d.en[q]),
            .strict    (r_d.strict[q]),
            .len       (frame_len[q*LENW +: LENW]),
            .npb       (ns_per_bit),
            .gate      (gate_open[q]),
            .admit     (admit[q])
        );
    end

    logic [1:0]      st_now;
    logic [TW-1:0]   cs_now;
    logic [OFFW-1:0] cyc_now;
    assign st_now  = r_q.state;
    assign cs_now  = r_q.cs;
    assign cyc_now = r_q.cyc;
endmodule

// File: rtl/tx_gate_sched_chk.sv
module tx_gate_sched_chk
    import tgs_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int TW   = 48,
    parameter int OFFW = 32,
    parameter int LENW = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         state,
    input logic [TW-1:0]      cs,
    input logic [OFFW-1:0]    cyc,
    input logic [NQ-1:0]      gate_open,
    input logic [NQ-1:0]      admit,
    input logic [NQ*LENW-1:0] frame_len
);
    AST_IDLE_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (gate_open == {NQ{1'b1}})); // R1

    AST_ALIGN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN) |-> (gate_open == '0)); // R3

    AST_ADMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (admit & ~gate_open) == '0); // R9

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN)); // R12

    AST_START_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && ($past(state) == ST_RUN) && (cs != $past(cs)))
        |-> (cs == $past(cs) + TW'($past(cyc)))); // R7

    for (genvar q = 0; q < NQ; q++) begin : g_len
        AST_SCHED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            ((state == ST_RUN) && admit[q])
            |-> (32'(frame_len[q*LENW +: LENW]) <= SCHED_MAX_BYTES)); // R10

        AST_IDLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            ((state == ST_IDLE) && admit[q])
            |-> (32'(frame_len[q*LENW +: LENW]) <= JUMBO_MAX_BYTES)); // R2
    end
endmodule

bind tx_gate_sched tx_gate_sched_chk #(
    .NQ(NQ), .TW(TW), .OFFW(OFFW), .LENW(LENW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st_now),
    .cs        (cs_now),
    .cyc       (cyc_now),
    .gate_open (gate_open),
    .admit     (admit),
    .frame_len (frame_len)
);

// File: tb/tx_gate_sched_test.sv
`timescale 1ns/1ps
module tx_gate_sched_test;
    localparam int  PERIOD = 8;
    localparam longint STEP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] now_ns = '0;
    logic        sched_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [55:0] frame_len = '0;
    logic [3:0]  ns_per_bit = 4'd1;
    logic [3:0]  gate_open;
    logic [3:0]  admit;

    tx_gate_sched uut (
        .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .sched_en(sched_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frame_len(frame_len), .ns_per_bit(ns_per_bit),
        .gate_open(gate_open), .admit(admit)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    longint m_now = 0, m_cs = 0, m_cyc = 1000000000;
    int     m_mode = 0;
    longint m_st[4], m_en[4];
    bit [3:0] m_strict;
    longint s_nsec, s_sec, s_cyc, s_st[4], s_en[4];
    bit [3:0] s_strict;
    int     lens[4];
    int     npb = 1;
    bit     b_we = 0, b_en = 0;
    int     b_addr = 0;
    longint b_data = 0;

    task automatic check(string what, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (now=%0d)", tag, what, act, exp, m_now);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_cs = 0; m_cyc = 1000000000; m_strict = 0; s_strict = 0;
        s_nsec = 0; s_sec = 0; s_cyc = 1000000000;
        for (int q = 0; q < 4; q++) begin
            m_st[q] = 0; m_en[q] = 1000000000; s_st[q] = 0; s_en[q] = 1000000000;
        end
    endtask

    task automatic step();
        logic [3:0] eg, ea;
        longint ccs, ccyc, el;
        longint cst[4], cen[4];
        bit [3:0] cstr;
        bit live;
        @(negedge clk);
        m_now += STEP;
        now_ns    = 48'(m_now);
        sched_en  = b_en;
        cfg_we    = b_we;
        cfg_addr  = 4'(b_addr);
        cfg_wdata = 32'(b_data);
        frame_len = {14'(lens[3]), 14'(lens[2]), 14'(lens[1]), 14'(lens[0])};
        ns_per_bit = 4'(npb);
        #1;
        ccs = m_cs; ccyc = m_cyc; cst = m_st; cen = m_en; cstr = m_strict;
        if (m_mode == 2 && m_now >= m_cs + m_cyc) begin
            ccs = m_cs + m_cyc; ccyc = s_cyc; cst = s_st; cen = s_en; cstr = s_strict;
        end
        live = (m_mode == 2) && (m_now >= ccs);
        for (int q = 0; q < 4; q++) begin
            if (m_mode == 0) begin
                eg[q] = 1'b1;
                ea[q] = (lens[q] <= 9728);
            end else begin
                el = m_now - ccs;
                eg[q] = live && (el >= cst[q]) && (el < cen[q]);
                ea[q] = eg[q] && (lens[q] <= 1600) &&
                        (!cstr[q] || (m_now + longint'(lens[q]) * 8 * npb <= ccs + cen[q]));
            end
        end
        check("gate", gate_open, eg);
        check("admit", admit, ea);
        case (m_mode)
            0: if (b_en) begin
                m_mode = 1; m_cs = s_sec * 1000000000 + s_nsec; m_cyc = s_cyc;
                m_st = s_st; m_en = s_en; m_strict = s_strict;
            end
            1: if (m_cs > m_now) m_mode = 2; else m_cs += m_cyc;
            default: begin
                m_cs = ccs; m_cyc = ccyc; m_st = cst; m_en = cen; m_strict = cstr;
            end
        endcase
        if (b_we) begin
            case (b_addr)
                0: s_nsec = b_data;
                1: s_sec = b_data;
                2: s_cyc = b_data;
                3: s_strict = 4'(b_data);
                default: begin
                    if (b_addr % 2 == 0) s_st[(b_addr - 4) / 2] = b_data;
                    else                 s_en[(b_addr - 5) / 2] = b_data;
                end
            endcase
        end
        b_we = 0;
    endtask

    task automatic wr(int a, longint d);
        b_we = 1; b_addr = a; b_data = d;
        step();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        b_en = 0; b_we = 0;
        @(negedge clk);
        rst_n = 1'b0; sched_en = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        model_reset();
        lens = '{9728, 9729, 100, 1600};
        do_reset();

        tag = "R1 R2";
        run(6);

        tag = "R13 R1";
        wr(2, 1000);
        wr(4, 0);   wr(5, 300);
        wr(6, 200); wr(7, 600);
        wr(8, 500); wr(9, 1000);
        wr(10, 700); wr(11, 700);
        wr(3, 4'b0010);
        lens = '{50, 40, 1601, 64};
        wr(0, m_now + STEP + 400);

        tag = "R3 R5 R6 R7 R8 R10";
        b_en = 1;
        run(400);

        tag = "R9 R7";
        lens = '{50, 40, 100, 64};
        run(150);

        tag = "R11";
        wr(5, 800);
        run(200);
        while (!(m_mode == 2 && m_now + STEP >= m_cs + m_cyc)) step();
        wr(6, 100);    // lands in the rollover cycle
        run(300);

        tag = "R12";
        b_en = 0;
        wr(0, 0);
        wr(1, 3);
        run(250);

        do_reset();
        tag = "R12 R1";
        run(5);

        tag = "R4";
        m_now = 5000;
        lens = '{64, 64, 64, 64};
        wr(2, 700);
        wr(4, 0);   wr(5, 100);
        wr(6, 0);   wr(7, 700);
        wr(8, 300); wr(9, 400);
        wr(10, 100); wr(11, 50);
        wr(0, 1000);
        b_en = 1;
        run(400);

        do_reset();
        tag = "R3 R13";
        m_now = 999998000;
        wr(1, 1);
        wr(2, 1000);
        b_en = 1;
        run(400);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule